// File: doc/BRIEF.md
# Multiplexed Asynchronous Register Bus Slave

This block lets a master load setup constants into a chip over a shared 8-bit bus. The same eight lines carry an address and then a data byte. Four active-low strobes pace each transfer with a four-phase handshake. The master lowers the address strobe, and the slave answers with an address acknowledge. The master then lowers the data strobe, and the slave answers with a data acknowledge. A direction input chooses between a write and a read. The upper four address bits name a chip and the lower four name one of up to sixteen 8-bit registers inside it. The registers drive a flat output vector that the surrounding logic uses as configuration.

Several slaves share the two acknowledge lines and the bus. The slave never drives an acknowledge high. It asserts a pull-enable output, which the board turns into a low level against an external pull-up. The address acknowledge is given only when the chip is selected and the named register exists. Chip selection comes from an internal compare with a fixed chip number, or from an external active-low select when a parameter says so. The two strobes pass through two-flop synchronizers on the local clock. On a read, the slave drives the register onto the bus and holds back the data acknowledge for a programmable number of clock cycles, so that the loaded bus has time to settle.

Top module: `mux_reg_slave`

## Requirements
- R1: After reset every register is 0, so `cfg_o` is all zeros. Both acknowledge pull-enables are low and the bus output enable is low.
- R2: The address acknowledge is given only when two things hold: the chip is selected and the register index in address bits [3:0] is below NREG. Otherwise neither acknowledge is asserted during that cycle.
- R3: On a write (`rd_wr`=0), the data byte is stored into register `idx`, which appears at `cfg_o[idx*8 +: 8]`. The data acknowledge is then asserted, and it is released after the data strobe rises.
- R4: On a read (`rd_wr`=1), the slave drives register `idx` onto `ad_o` with `ad_oe` high. The data acknowledge rises exactly RD_DELAY+1 clock cycles after `ad_oe` rises.
- R5: The bus output enable is high only during an acknowledged read. It and the data acknowledge are released after the data strobe rises.
- R6: Once given, the address acknowledge stays asserted while the synchronized address strobe is low. It is released in the cycle after the strobe is seen high.
- R7: With USE_EXT_CS=1, the chip-number compare is ignored. Selection follows only the active-low `cs_n` input, sampled at the address strobe.
- R8: A write that is not acknowledged changes no register, and an acknowledged write changes only its own register.
- R9: The data acknowledge is never asserted without the address acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_i | input | 8 | Bus value as seen at the pins: the address, then the write data |
| ad_o | output | 8 | Read data driven toward the bus |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rd_wr | input | 1 | Cycle type: 1 is read, 0 is write; sampled with the address |
| cs_n | input | 1 | External chip select, active low; used only when USE_EXT_CS=1 |
| ak_pull | output | 1 | When 1, pull the shared address acknowledge line low |
| dk_pull | output | 1 | When 1, pull the shared data acknowledge line low |
| cfg_o | output | NREG*8 | Flat vector of all registers; register i at bits [i*8 +: 8] |

## Verification
The embedded properties check on every cycle these handshake rules:
- the data acknowledge stays nested inside the address acknowledge;
- both acknowledges keep or drop in step with the synchronized strobes;
- the bus is driven only while the address is acknowledged;
- the read acknowledge rises at exactly the programmed distance from the start of driving.

Only the bench scenarios can show the following:
- which addresses are acknowledged across chip numbers and register indices;
- that write data lands in the right slice of the output vector and nowhere else;
- that reads return the stored bytes;
- that two slaves, one using the compare and one using the external select, share the acknowledge lines and the bus without conflict.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_MISS,
        S_ADDR,
        S_WACK,
        S_RDLY,
        S_RACK,
        S_HOLD
    } mrs_state_e;
endpackage

// File: rtl/mrs_sync.sv
module mrs_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= din;
            stab_q <= meta_q;
        end
    end

    assign dout = stab_q;
endmodule

// File: rtl/mrs_regfile.sv
module mrs_regfile #(
    parameter int NREG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [3:0]      widx,
    input  logic [7:0]      wdata,
    input  logic [3:0]      ridx,
    output logic [7:0]      rdata,
    output logic [NREG*8-1:0] flat
);
    logic [7:0] regs_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (we && (widx == 4'(i))) begin
                regs_q[i] <= wdata;
            end
        end
        assign flat[i*8 +: 8] = regs_q[i];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (ridx == 4'(i)) rdata = regs_q[i];
        end
    end
endmodule

// File: rtl/mux_reg_slave.sv
module mux_reg_slave
    import mrs_pkg::*;
#(
    parameter int         NREG       = 8,
    parameter logic [3:0] CHIP_ID    = 4'h5,
    parameter int         RD_DELAY   = 10,
    parameter bit         USE_EXT_CS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        ad_i,
    output logic [7:0]        ad_o,
    output logic              ad_oe,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rd_wr,
    input  logic              cs_n,
    output logic              ak_pull,
    output logic              dk_pull,
    output logic [NREG*8-1:0] cfg_o
);
    localparam int              CW       = $clog2(RD_DELAY + 2);
    localparam logic [CW-1:0]   DLY_LAST = CW'(RD_DELAY);
    localparam logic [CW:0]     OE_EXP   = (CW+1)'(RD_DELAY + 1);

    typedef struct packed {
        mrs_state_e    st;
        logic [3:0]    idx;
        logic          rw;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [1:0] strb_s;
    logic       as_lo, ds_lo;
    logic       sel_ok, hit, wr_en;
    logic [7:0] rd_byte;

    mrs_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({as_n, ds_n}),
        .dout (strb_s)
    );
    assign as_lo = !strb_s[1];
    assign ds_lo = !strb_s[0];

    if (USE_EXT_CS) begin : g_ext_sel
        assign sel_ok = !cs_n;
    end else begin : g_cmp_sel
        assign sel_ok = (ad_i[7:4] == CHIP_ID);
    end

    assign hit = sel_ok && (int'(ad_i[3:0]) < NREG);

    always_comb begin
        ctl_d = ctl_q;
        wr_en = 1'b0;
        case (ctl_q.st)
            S_IDLE: begin
                if (as_lo) begin
                    ctl_d.idx = ad_i[3:0];
                    ctl_d.rw  = rd_wr;
                    ctl_d.st  = hit ? S_ADDR : S_MISS;
                end
            end
            S_MISS: begin
                if (!as_lo) ctl_d.st = S_IDLE;
            end
            S_ADDR: begin
                if (!as_lo) begin
                    ctl_d.st = S_IDLE;
                end else if (ds_lo) begin
                    if (ctl_q.rw) begin
                        ctl_d.st  = S_RDLY;
                        ctl_d.cnt = '0;
                    end else begin
                        wr_en    = 1'b1;
                        ctl_d.st = S_WACK;
                    end
                end
            end
            S_WACK: begin
                if (!as_lo)      ctl_d.st = S_IDLE;
                else if (!ds_lo) ctl_d.st = S_HOLD;
            end
            S_RDLY: begin
                if (!as_lo)                  ctl_d.st = S_IDLE;
                else if (ctl_q.cnt == DLY_LAST) ctl_d.st = S_RACK;
                else                         ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            S_RACK: begin
                if (!as_lo)      ctl_d.st = S_IDLE;
                else if (!ds_lo) ctl_d.st = S_HOLD;
            end
            S_HOLD: begin
                if (!as_lo) ctl_d.st = S_IDLE;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, idx: '0, rw: 1'b0, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    mrs_regfile #(.NREG(NREG)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en),
        .widx (ctl_q.idx),
        .wdata(ad_i),
        .ridx (ctl_q.idx),
        .rdata(rd_byte),
        .flat (cfg_o)
    );

    assign ak_pull = (ctl_q.st == S_ADDR) || (ctl_q.st == S_WACK) || (ctl_q.st == S_RDLY)
                  || (ctl_q.st == S_RACK) || (ctl_q.st == S_HOLD);
    assign dk_pull = (ctl_q.st == S_WACK) || (ctl_q.st == S_RACK);
    assign ad_oe   = (ctl_q.st == S_RDLY) || (ctl_q.st == S_RACK);
    assign ad_o    = rd_byte;

    logic [CW:0] oe_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           oe_run_q <= '0;
        else if (!ad_oe)      oe_run_q <= '0;
        else if (oe_run_q != '1) oe_run_q <= oe_run_q + 1'b1;
    end

    a_r9_dk_inside_ak: assert property (@(posedge clk) disable iff (!rst_n)
        dk_pull |-> ak_pull);
    a_r6_ak_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ak_pull && !as_lo) |=> !ak_pull);
    a_r6_ak_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (ak_pull && as_lo) |=> ak_pull);
    a_r5_oe_only_acked: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> ak_pull);
    a_r3_dk_release: assert property (@(posedge clk) disable iff (!rst_n)
        (dk_pull && !ds_lo) |=> !dk_pull);
    a_r4_read_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dk_pull) && ad_oe) |-> (oe_run_q == OE_EXP));
endmodule

// File: tb/test_mux_reg_slave.sv
module test_mux_reg_slave;
    localparam int NR0 = 8;
    localparam int NR1 = 4;
    localparam int DL0 = 10;
    localparam int DL1 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic as_n = 1'b1, ds_n = 1'b1, rw = 1'b0;
    logic m_drv = 1'b0;
    logic [7:0] m_val = 8'h00;
    logic [7:0] bus, ado0, ado1;
    logic oe0, oe1, akp0, akp1, dkp0, dkp1, ak_n, dk_n, cs1_n, oe_any;
    logic [NR0*8-1:0] cfg0;
    logic [NR1*8-1:0] cfg1;

    assign bus    = oe0 ? ado0 : (oe1 ? ado1 : (m_drv ? m_val : 8'hFF));
    assign ak_n   = !(akp0 || akp1);
    assign dk_n   = !(dkp0 || dkp1);
    assign cs1_n  = !(bus[7:4] == 4'hA);
    assign oe_any = oe0 || oe1;

    mux_reg_slave #(.NREG(NR0), .CHIP_ID(4'h5), .RD_DELAY(DL0), .USE_EXT_CS(1'b0)) i_mux_reg_slave (
        .clk(clk), .rst_n(rst_n), .ad_i(bus), .ad_o(ado0), .ad_oe(oe0),
        .as_n(as_n), .ds_n(ds_n), .rd_wr(rw), .cs_n(1'b1),
        .ak_pull(akp0), .dk_pull(dkp0), .cfg_o(cfg0));

    mux_reg_slave #(.NREG(NR1), .CHIP_ID(4'h3), .RD_DELAY(DL1), .USE_EXT_CS(1'b1)) i_ext (
        .clk(clk), .rst_n(rst_n), .ad_i(bus), .ad_o(ado1), .ad_oe(oe1),
        .as_n(as_n), .ds_n(ds_n), .rd_wr(rw), .cs_n(cs1_n),
        .ak_pull(akp1), .dk_pull(dkp1), .cfg_o(cfg1));

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] exp0 [NR0];
    logic [7:0] exp1 [NR1];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_hit(input logic [3:0] chip, input logic [3:0] idx);
        return (chip == 4'h5 && int'(idx) < NR0) || (chip == 4'hA && int'(idx) < NR1);
    endfunction

    task automatic cfg_compare(input string req);
        for (int i = 0; i < NR0; i++) chk(cfg0[i*8 +: 8] == exp0[i], req, cfg0[i*8 +: 8], exp0[i]);
        for (int i = 0; i < NR1; i++) chk(cfg1[i*8 +: 8] == exp1[i], req, cfg1[i*8 +: 8], exp1[i]);
    endtask

    task automatic do_cycle(input logic [7:0] addr, input bit rd, input logic [7:0] wdat,
                            output bit acked, output logic [7:0] rdat, output int dly);
        bit stray;
        int t, t0;
        acked = 1'b0; rdat = 8'h00; dly = -1; stray = 1'b0;
        @(negedge clk);
        m_drv = 1'b1; m_val = addr; rw = rd;
        repeat (2) @(negedge clk);
        as_n = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (!dk_n) stray = 1'b1;
            if (!ak_n) begin acked = 1'b1; break; end
        end
        if (!acked) begin
            as_n = 1'b1;
            repeat (6) @(negedge clk);
            m_drv = 1'b0;
            chk(!stray && ak_n && dk_n, "R2 no ack on miss", {ak_n, dk_n}, 3);
            return;
        end
        if (!rd) begin
            m_val = wdat;
            repeat (2) @(negedge clk);
            ds_n = 1'b0;
            t = 0;
            while (dk_n && t < 20) begin @(negedge clk); t++; end
            chk(!dk_n, "R3 write data ack", dk_n, 0);
        end else begin
            m_drv = 1'b0;
            @(negedge clk);
            ds_n = 1'b0;
            t = 0; t0 = -1;
            while (t < 40) begin
                @(negedge clk);
                t++;
                if (oe_any && t0 < 0) t0 = t;
                if (!dk_n) break;
            end
            chk(!dk_n, "R4 read data ack", dk_n, 0);
            dly = t - t0;
            rdat = bus;
        end
        ds_n = 1'b1;
        t = 0;
        while (!dk_n && t < 20) begin @(negedge clk); t++; end
        repeat (2) @(negedge clk);
        chk(dk_n && !oe_any, "R5 release after data strobe", {dk_n, oe_any}, 2);
        chk(!ak_n, "R6 address ack held", ak_n, 0);
        as_n = 1'b1;
        t = 0;
        while (!ak_n && t < 20) begin @(negedge clk); t++; end
        chk(ak_n && t <= 4, "R6 address ack released", t, 3);
        m_drv = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(150000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bit ak;
        logic [7:0] rb;
        int dl;
        logic [3:0] chips [3];
        chips[0] = 4'h5; chips[1] = 4'hA; chips[2] = 4'h3;
        for (int i = 0; i < NR0; i++) exp0[i] = 8'h00;
        for (int i = 0; i < NR1; i++) exp1[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ak_n && dk_n && !oe_any, "R1 idle outputs", {ak_n, dk_n, oe_any}, 6);
        cfg_compare("R1 reset registers");

        for (int c = 0; c < 3; c++) begin
            for (int ix = 0; ix < 16; ix++) begin
                logic [7:0] a, d;
                a = {chips[c], 4'(ix)};
                d = a ^ 8'hC3;
                do_cycle(a, 1'b0, d, ak, rb, dl);
                chk(ak == exp_hit(chips[c], 4'(ix)), "R2 R7 write ack decode", ak, exp_hit(chips[c], 4'(ix)));
                if (ak && chips[c] == 4'h5) exp0[ix] = d;
                if (ak && chips[c] == 4'hA) exp1[ix] = d;
                cfg_compare("R3 R8 register contents");
            end
        end

        for (int c = 0; c < 3; c++) begin
            for (int ix = 0; ix < 16; ix++) begin
                logic [7:0] a;
                bit eh;
                a = {chips[c], 4'(ix)};
                eh = exp_hit(chips[c], 4'(ix));
                do_cycle(a, 1'b1, 8'h00, ak, rb, dl);
                chk(ak == eh, "R2 R7 read ack decode", ak, eh);
                if (ak) begin
                    if (chips[c] == 4'h5) begin
                        chk(rb == exp0[ix], "R4 read data", rb, exp0[ix]);
                        chk(dl == DL0 + 1, "R4 read delay", dl, DL0 + 1);
                    end else begin
                        chk(rb == exp1[ix], "R4 R7 read data", rb, exp1[ix]);
                        chk(dl == DL1 + 1, "R4 R7 read delay", dl, DL1 + 1);
                    end
                end
            end
        end
        cfg_compare("R8 reads leave registers");
        chk(ak_n && dk_n && !oe_any, "R5 idle after sweep", {ak_n, dk_n, oe_any}, 6);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule